// File: doc/BRIEF.md
# Eight-Point Radix-2 Decimation-in-Time FFT

This block computes an 8-point complex discrete Fourier transform of a burst of fixed-point samples. A producer pushes eight complex samples, x(0) first, through a valid/ready handshake. Each sample is written into an internal register array at the bit-reversed position of its arrival index. This places the data where the first decimation-in-time stage expects it. A shorter sequence is extended to eight points by sending zeros for the missing samples.

Once the eighth sample is in, the block runs three butterfly stages in place, one butterfly per clock, for twelve cycles. Each butterfly takes two values a and b, multiplies b by a twiddle W and writes back (a + bW)/2 and (a - bW)/2. Stage one uses only W = 1. Stage two uses powers 0 and 2 of the eighth root of unity. Stage three uses powers 0 to 3. Multiplying by 1 or by -j needs no multiplier. The halving at each stage scales the final result by 1/8.

The results X(0) to X(7) then leave in natural order through a second valid/ready handshake. While the block computes or unloads it reports busy and accepts no input.

Top module: `fft8_dit`

## Requirements
- R1: While reset is held and just after it, in_ready is 1, busy is 0 and out_valid is 0.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. The k-th sample taken in a block is x(k). Component fields are 16-bit two's complement.
- R3: In the cycle after the eighth sample of a block is taken, busy is 1 and in_ready is 0.
- R4: busy stays 1 until the edge that accepts X(7). In the following cycle busy is 0 and in_ready is 1.
- R5: An in_valid pulse while busy is 1 takes no sample and leaves the results of the current block unchanged.
- R6: out_valid rises exactly twelve cycles after busy rises, one butterfly per cycle.
- R7: Outputs appear in the order X(0) to X(7). Each real and imaginary part of X(k) is within ±2 LSB of (1/8)·Σ x(n)·e^(−j2πkn/8), for input components within ±16383.
- R8: For input components within ±16383, no butterfly result exceeds the signed 16-bit range.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_re and out_im do not change.
- R10: A zero-padded block {1000, 2000, 3000, 4000, 0, 0, 0, 0} with zero imaginary parts gives X(0) = 1250 + j0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a sample |
| in_ready | output | 1 | Block is able to take a sample |
| in_re | input | 16 | Real part of the offered sample |
| in_im | input | 16 | Imaginary part of the offered sample |
| out_valid | output | 1 | A transform result is presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_re | output | 16 | Real part of X(k) |
| out_im | output | 16 | Imaginary part of X(k) |
| busy | output | 1 | Block is computing or unloading |

## Verification
Four properties are checked on every cycle:
- busy rises once the last sample of a block is taken.
- busy is released after the last result is accepted.
- The butterfly sequence lasts exactly twelve cycles before the first result appears.
- A stalled result stays steady, and no butterfly output overflows.

The numerical accuracy of each bin, the natural output order, the zero-padded case and the immunity to input offered while busy are shown only by the bench scenarios. In those scenarios a floating-point DFT is compared with every presented output.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  parameter int DW   = 16;
  parameter int WW   = 16;
  localparam int NPT  = 8;
  localparam int LOGN = $clog2(NPT);
  localparam int NBF  = NPT / 2;

  typedef enum logic [1:0] {PH_LOAD, PH_RUN, PH_DRAIN} phase_e;
  typedef enum logic [1:0] {TW_ONE, TW_NEGJ, TW_MUL} twk_e;

  function automatic logic [LOGN-1:0] bitrev(input logic [LOGN-1:0] v);
    logic [LOGN-1:0] r;
    for (int i = 0; i < LOGN; i++) r[i] = v[LOGN-1-i];
    return r;
  endfunction
endpackage

// File: rtl/fft8_twiddle.sv
module fft8_twiddle
  import fft8_pkg::*;
#(
  parameter int TW_W  = WW,
  parameter int IDX_W = LOGN - 1
) (
  input  logic [IDX_W-1:0]       idx,
  output logic signed [TW_W-1:0] w_re,
  output logic signed [TW_W-1:0] w_im,
  output twk_e                   kind
);
  localparam int ONE  = (1 << (TW_W - 1)) - 1;
  localparam int DIAG = int'(0.70710678118654752 * real'(1 << (TW_W - 1)));

  always_comb begin
    case (idx)
      2'd0:    begin w_re = TW_W'(ONE);   w_im = '0;             kind = TW_ONE;  end
      2'd1:    begin w_re = TW_W'(DIAG);  w_im = TW_W'(-DIAG);   kind = TW_MUL;  end
      2'd2:    begin w_re = '0;           w_im = TW_W'(-ONE);    kind = TW_NEGJ; end
      default: begin w_re = TW_W'(-DIAG); w_im = TW_W'(-DIAG);   kind = TW_MUL;  end
    endcase
  end
endmodule

// File: rtl/fft8_bfly.sv
module fft8_bfly
  import fft8_pkg::*;
#(
  parameter int D_W  = DW,
  parameter int TW_W = WW
) (
  input  logic signed [D_W-1:0]  a_re,
  input  logic signed [D_W-1:0]  a_im,
  input  logic signed [D_W-1:0]  b_re,
  input  logic signed [D_W-1:0]  b_im,
  input  logic signed [TW_W-1:0] w_re,
  input  logic signed [TW_W-1:0] w_im,
  input  twk_e                   kind,
  output logic signed [D_W-1:0]  s_re,
  output logic signed [D_W-1:0]  s_im,
  output logic signed [D_W-1:0]  d_re,
  output logic signed [D_W-1:0]  d_im,
  output logic                   ovf
);
  localparam int PW = D_W + TW_W + 1;
  localparam int XW = D_W + 2;

  // Q1.(TW_W-1) product term x1*c1 -/+ x2*c2, rounded to nearest
  function automatic logic signed [XW-1:0] qmac(
    input logic signed [D_W-1:0] x1, input logic signed [TW_W-1:0] c1,
    input logic signed [D_W-1:0] x2, input logic signed [TW_W-1:0] c2,
    input logic sub);
    logic signed [PW-1:0] m1, m2, acc;
    m1  = PW'(x1) * PW'(c1);
    m2  = PW'(x2) * PW'(c2);
    acc = (sub ? (m1 - m2) : (m1 + m2)) + (PW'(1) <<< (TW_W - 2));
    return XW'(acc >>> (TW_W - 1));
  endfunction

  // (a +/- p) / 2, rounded half up
  function automatic logic signed [XW:0] halve(
    input logic signed [D_W-1:0] a, input logic signed [XW-1:0] p, input logic sub);
    logic signed [XW:0] t;
    t = sub ? ((XW+1)'(a) - (XW+1)'(p)) : ((XW+1)'(a) + (XW+1)'(p));
    return (t + (XW+1)'(1)) >>> 1;
  endfunction

  function automatic logic fits(input logic signed [XW:0] v);
    return (v[XW:D_W-1] == '0) || (v[XW:D_W-1] == '1);
  endfunction

  logic signed [XW-1:0] p_re, p_im;
  logic signed [XW:0]   hs_re, hs_im, hd_re, hd_im;

  always_comb begin
    case (kind)
      TW_ONE:  begin p_re = XW'(b_re); p_im = XW'(b_im);  end
      TW_NEGJ: begin p_re = XW'(b_im); p_im = -XW'(b_re); end
      default: begin
        p_re = qmac(b_re, w_re, b_im, w_im, 1'b1);
        p_im = qmac(b_re, w_im, b_im, w_re, 1'b0);
      end
    endcase
    hs_re = halve(a_re, p_re, 1'b0);
    hs_im = halve(a_im, p_im, 1'b0);
    hd_re = halve(a_re, p_re, 1'b1);
    hd_im = halve(a_im, p_im, 1'b1);
    s_re  = D_W'(hs_re);
    s_im  = D_W'(hs_im);
    d_re  = D_W'(hd_re);
    d_im  = D_W'(hd_im);
    ovf   = !(fits(hs_re) && fits(hs_im) && fits(hd_re) && fits(hd_im));
  end
endmodule

// File: rtl/fft8_dit.sv
module fft8_dit
  import fft8_pkg::*;
#(
  parameter int D_W  = DW,
  parameter int TW_W = WW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [D_W-1:0]       in_re,
  input  logic [D_W-1:0]       in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [D_W-1:0]       out_re,
  output logic [D_W-1:0]       out_im,
  output logic                 busy
);
  localparam int IW = LOGN;
  localparam int SW = $clog2(LOGN);
  localparam int BW = LOGN - 1;

  phase_e               phase;
  logic [IW-1:0]        cnt;
  logic [SW-1:0]        stage;
  logic [BW-1:0]        bf;
  logic signed [D_W-1:0] mre [NPT];
  logic signed [D_W-1:0] mim [NPT];

  logic [IW-1:0]        top_idx, bot_idx;
  logic [BW-1:0]        tw_idx;
  logic signed [TW_W-1:0] w_re, w_im;
  twk_e                 tw_kind;
  logic signed [D_W-1:0] s_re, s_im, d_re, d_im;

  // named events for the checks
  logic bf_fire, bf_ovf, load_last, drain_last;

  always_comb begin
    int h, pos, grp;
    h   = 1 << int'(stage);
    pos = int'(bf) & (h - 1);
    grp = int'(bf) >> int'(stage);
    top_idx = IW'(grp * 2 * h + pos);
    bot_idx = IW'(grp * 2 * h + pos + h);
    tw_idx  = BW'(pos << (LOGN - 1 - int'(stage)));
  end

  fft8_twiddle #(.TW_W(TW_W), .IDX_W(BW)) u_rom (
    .idx(tw_idx), .w_re(w_re), .w_im(w_im), .kind(tw_kind)
  );

  fft8_bfly #(.D_W(D_W), .TW_W(TW_W)) u_bfly (
    .a_re(mre[top_idx]), .a_im(mim[top_idx]),
    .b_re(mre[bot_idx]), .b_im(mim[bot_idx]),
    .w_re(w_re), .w_im(w_im), .kind(tw_kind),
    .s_re(s_re), .s_im(s_im), .d_re(d_re), .d_im(d_im),
    .ovf(bf_ovf)
  );

  assign in_ready   = (phase == PH_LOAD);
  assign out_valid  = (phase == PH_DRAIN);
  assign busy       = (phase != PH_LOAD);
  assign bf_fire    = (phase == PH_RUN);
  assign load_last  = in_valid && in_ready && (cnt == IW'(NPT - 1));
  assign drain_last = out_valid && out_ready && (cnt == IW'(NPT - 1));
  assign out_re     = mre[cnt];
  assign out_im     = mim[cnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      cnt   <= '0;
      stage <= '0;
      bf    <= '0;
      for (int i = 0; i < NPT; i++) begin
        mre[i] <= '0;
        mim[i] <= '0;
      end
    end else begin
      case (phase)
        PH_LOAD: if (in_valid) begin
          mre[bitrev(cnt)] <= in_re;
          mim[bitrev(cnt)] <= in_im;
          cnt <= cnt + 1'b1;
          if (load_last) begin
            phase <= PH_RUN;
            stage <= '0;
            bf    <= '0;
          end
        end
        PH_RUN: begin
          mre[top_idx] <= s_re;
          mim[top_idx] <= s_im;
          mre[bot_idx] <= d_re;
          mim[bot_idx] <= d_im;
          bf <= bf + 1'b1;
          if (bf == BW'(NBF - 1)) begin
            bf <= '0;
            if (stage == SW'(LOGN - 1)) begin
              phase <= PH_DRAIN;
              cnt   <= '0;
            end else begin
              stage <= stage + 1'b1;
            end
          end
        end
        default: if (out_ready) begin
          cnt <= cnt + 1'b1;
          if (drain_last) phase <= PH_LOAD;
        end
      endcase
    end
  end

  // R3: last sample taken -> compute starts next cycle
  p_load_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_last |=> busy && !in_ready);

  // R4: last result taken -> released next cycle
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last |=> !busy && in_ready);

  // R6: first result follows the final butterfly of the final stage
  p_pipe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(bf_fire) && ($past(stage) == SW'(LOGN - 1))
                         && ($past(bf) == BW'(NBF - 1)));

  // R8: butterfly results stay inside the sample range
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bf_fire |-> !bf_ovf);

  // R9: stalled output holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im));
endmodule

// File: tb/test_fft8_dit.sv
module test_fft8_dit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, busy;
  logic signed [15:0] out_re, out_im;

  fft8_dit i_fft8_dit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .busy(busy)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input real act, input real expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0f expected %0f", tag, what, act, expv);
    end
  endtask

  // behavioural reference: phase, counters, queue of expected bins
  int m = 0, k = 0, lcnt = 0, ocnt = 0;
  bit post_drain = 0;
  int lr [8], li [8];
  real qr [$], qi [$];
  string blk_tag = "R7";
  int xr [8], xi [8];

  task automatic make_ref();
    for (int b = 0; b < 8; b++) begin
      real sr, si, ang;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < 8; n++) begin
        ang = -2.0 * 3.14159265358979 * real'(b * n) / 8.0;
        sr += real'(lr[n]) * $cos(ang) - real'(li[n]) * $sin(ang);
        si += real'(lr[n]) * $sin(ang) + real'(li[n]) * $cos(ang);
      end
      qr.push_back(sr / 8.0);
      qi.push_back(si / 8.0);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string t;
      real dr, di;
      t = (m == 0) ? (post_drain ? "R4" : "R2") : ((m == 1) ? "R3" : "R6");
      check(in_ready == (m == 0), t, "in_ready", real'(in_ready), real'(m == 0));
      check(busy == (m != 0), t, "busy", real'(busy), real'(m != 0));
      check(out_valid == (m == 2), t, "out_valid", real'(out_valid), real'(m == 2));
      post_drain = 0;
      case (m)
        0: if (in_valid) begin
          lr[lcnt] = int'(in_re);
          li[lcnt] = int'(in_im);
          lcnt++;
          if (lcnt == 8) begin make_ref(); lcnt = 0; m = 1; k = 0; end
        end
        1: begin k++; if (k == 12) begin m = 2; ocnt = 0; end end
        default: begin
          dr = real'(out_re) - qr[0];
          di = real'(out_im) - qi[0];
          check(dr <= 2.0 && dr >= -2.0, blk_tag, $sformatf("X(%0d) re", ocnt), real'(out_re), qr[0]);
          check(di <= 2.0 && di >= -2.0, blk_tag, $sformatf("X(%0d) im", ocnt), real'(out_im), qi[0]);
          if (out_ready) begin
            void'(qr.pop_front());
            void'(qi.pop_front());
            ocnt++;
            if (ocnt == 8) begin m = 0; post_drain = 1; end
          end
        end
      endcase
    end
  end

  task automatic load_block(input bit junk);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #2;
      in_valid = 1'b1; in_re = 16'(xr[i]); in_im = 16'(xi[i]);
    end
    @(posedge clk); #2;
    if (junk) begin in_re = 16'sh5a5a; in_im = -16'sh1234; end
    else in_valid = 1'b0;
  endtask

  task automatic drain(input bit throttle, input bit junk);
    int c = 0;
    do begin
      @(posedge clk); #2;
      c++;
      out_ready = throttle ? (c % 3 == 0) : 1'b1;
      if (junk) begin in_re = 16'($urandom); in_im = 16'($urandom); end
    end while (busy);
    in_valid = 1'b0;
    out_ready = 1'b0;
  endtask

  task automatic run_block(input string tag, input bit throttle, input bit junk);
    blk_tag = tag;
    load_block(junk);
    drain(throttle, junk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while held in reset
    check(in_ready == 1'b1, "R1", "in_ready", real'(in_ready), 1.0);
    check(busy == 1'b0, "R1", "busy", real'(busy), 0.0);
    check(out_valid == 1'b0, "R1", "out_valid", real'(out_valid), 0.0);
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !busy && !out_valid, "R1", "idle after reset", real'(busy), 0.0);

    // R7: impulse
    xr = '{16000, 0, 0, 0, 0, 0, 0, 0}; xi = '{-8000, 0, 0, 0, 0, 0, 0, 0};
    run_block("R7", 1'b0, 1'b0);
    // R10: zero-padded short sequence, X(0) = 1250
    xr = '{1000, 2000, 3000, 4000, 0, 0, 0, 0}; xi = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_block("R10", 1'b0, 1'b0);
    // R7: constant and alternating patterns
    xr = '{5000, 5000, 5000, 5000, 5000, 5000, 5000, 5000}; xi = xr;
    run_block("R7", 1'b0, 1'b0);
    xr = '{12000, -12000, 12000, -12000, 12000, -12000, 12000, -12000};
    xi = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_block("R7", 1'b0, 1'b0);
    // R8: bounded random data
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 8; i++) begin
        xr[i] = int'($urandom_range(24000)) - 12000;
        xi[i] = int'($urandom_range(24000)) - 12000;
      end
      run_block("R8", 1'b0, 1'b0);
    end
    // R9: stalled consumer
    for (int i = 0; i < 8; i++) begin xr[i] = 1500 * i - 5000; xi[i] = 3000 - 700 * i; end
    run_block("R9", 1'b1, 1'b0);
    // R5: input offered throughout compute and unload
    for (int i = 0; i < 8; i++) begin xr[i] = (i % 3) * 4000 - 3000; xi[i] = 2500 - 900 * i; end
    run_block("R5", 1'b1, 1'b1);
    // R4: a fresh block is accepted straight after release
    xr = '{-7000, 0, 3000, 0, 0, 6000, 0, 0}; xi = '{0, 2000, 0, 0, -4000, 0, 0, 1000};
    run_block("R7", 1'b0, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule